// File: doc/BRIEF.md
# Task Context Switch Sequencer

This block carries out the core of a hardware task switch for a small processor. It keeps a task register made of two parts: the selector of the running task and a cached copy of that task's descriptor, which gives the base address of the task's state segment in memory. A jump-to-task command names a new selector. The block then writes the live register set into the current segment, loads the task register with the new selector and its descriptor, and reads the register set back from the new segment. Control returns at the restored instruction pointer.

The live register set arrives on a flat context input and is captured in the cycle the command is taken. The restored register set appears on a flat context output. Descriptors come from a small table indexed by selector. The table has a write port, which the environment preloads before any switch. Memory is reached through a single-word request/acknowledge port. Each state segment holds one word per field in its lower part. The fields sit in this order: general registers, flags, instruction pointer, segment registers, privileged stack pointers, local descriptor table address and page directory address. Every word above these fields belongs to the operating system, and the block never addresses it.

Top module: `task_switch_seq`

## Requirements
- R1: After reset, busy_o, done_o and mem_req_o are 0, and tr_sel_o and tr_base_o are 0. Every descriptor table entry resets to base 0.
- R2: When jmp_i is high while busy_o is low, busy_o is high in the next cycle. The command is taken in that cycle, and ctx_i is captured at that same clock edge.
- R3: The save phase issues NUM_FIELDS writes (mem_we_o=1). Write k goes to address old_base+k and carries word k of the captured ctx_i. The word offsets are: general registers 0..3, flags 4, instruction pointer 5, segment registers 6..7, stack pointers 8..9, local table address 10, page directory address 11.
- R4: Every save write comes before the task register changes. tr_sel_o and tr_base_o take the new selector and its table base after the last write is acknowledged and before the first read. No write follows a read within a switch.
- R5: The restore phase issues NUM_FIELDS reads. Read k goes to address new_base+k, and its data becomes word k of ctx_o.
- R6: Every request addresses an offset in the range 0..NUM_FIELDS-1 from the current task register base. Segment words at offsets NUM_FIELDS and above are never touched.
- R7: busy_o stays high up to the final read acknowledge. In the next cycle, busy_o is low and done_o pulses for one cycle, with ip_o equal to restored word 5.
- R8: A jmp_i that arrives while busy_o is high is ignored. It changes neither the target nor the sequence.
- R9: When the target selector equals the current one, the full save and restore still runs, and ctx_o ends equal to the captured ctx_i.
- R10: While mem_req_o is high without mem_ack_i, the request, mem_addr_o, mem_we_o and mem_wdata_o hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dt_we_i | input | 1 | Descriptor table write enable |
| dt_idx_i | input | SEL_W | Descriptor table write index |
| dt_base_i | input | ADDR_W | Segment base written to the table |
| jmp_i | input | 1 | Jump-to-task command |
| jmp_sel_i | input | SEL_W | Target task selector |
| ctx_i | input | NUM_FIELDS*XLEN | Live register set, word k at bits k*XLEN |
| busy_o | output | 1 | Switch in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ip_o | output | XLEN | Restored instruction pointer |
| ctx_o | output | NUM_FIELDS*XLEN | Restored register set |
| tr_sel_o | output | SEL_W | Task register selector |
| tr_base_o | output | ADDR_W | Task register cached segment base |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_wdata_o | output | XLEN | Memory write data |
| mem_ack_i | input | 1 | Memory acknowledge, accepts the request this cycle |
| mem_rdata_i | input | XLEN | Read data, valid with acknowledge |

## Verification
The assertions check the following on every cycle:
- Request hold under wait states.
- The bound on offsets, which keeps accesses out of the operating-system area.
- The task register staying fixed across accepted accesses.
- No write following a read.
- The busy/done pulse shape.

Only the bench's switch scenarios can show the rest. Those scenarios check that the saved words match the context captured at the command, even though ctx_i changes afterwards. They also check that restored words come from the new segment, that a command arriving mid-switch leaves the target unchanged, and that a switch to the running task returns the same registers.

// File: rtl/tsw_pkg.sv
package tsw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SAVE,
    ST_LOAD_TR,
    ST_RESTORE
  } tsw_state_e;

  // gprs, flags, ip, segs, stack ptrs, ldt addr, page dir addr
  function automatic int unsigned ctx_words(int unsigned n_gpr, int unsigned n_seg,
                                            int unsigned n_stk);
    return n_gpr + n_seg + n_stk + 4;
  endfunction

  function automatic int unsigned ip_offset(int unsigned n_gpr);
    return n_gpr + 1;
  endfunction

endpackage

// File: rtl/tsw_desc_table.sv
module tsw_desc_table #(
  parameter int unsigned SEL_W  = 3,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SEL_W-1:0]  wr_idx_i,
  input  logic [ADDR_W-1:0] wr_base_i,
  input  logic [SEL_W-1:0]  rd_idx_i,
  output logic [ADDR_W-1:0] rd_base_o
);
  localparam int unsigned Depth = 1 << SEL_W;

  logic [ADDR_W-1:0] base_q [Depth];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < Depth; i++) base_q[i] <= '0;
    end else if (we_i) begin
      base_q[wr_idx_i] <= wr_base_i;
    end
  end

  assign rd_base_o = base_q[rd_idx_i];
endmodule

// File: rtl/tsw_fsm.sv
module tsw_fsm
  import tsw_pkg::*;
#(
  parameter int unsigned NF    = 12,
  parameter int unsigned CNT_W = $clog2(NF)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             jmp_i,
  input  logic             ack_i,
  output logic             start_o,
  output logic             req_o,
  output logic             we_o,
  output logic             tr_load_o,
  output logic             rd_acc_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] idx_o
);
  localparam logic [CNT_W-1:0] Last = CNT_W'(NF - 1);

  tsw_state_e       state_q;
  logic [CNT_W-1:0] idx_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (jmp_i) begin
          state_q <= ST_SAVE;
          idx_q   <= '0;
        end
        ST_SAVE: if (ack_i) begin
          if (idx_q == Last) begin
            state_q <= ST_LOAD_TR;
            idx_q   <= '0;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_LOAD_TR: state_q <= ST_RESTORE;
        ST_RESTORE: if (ack_i) begin
          if (idx_q == Last) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            done_q  <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign start_o   = (state_q == ST_IDLE) && jmp_i;
  assign req_o     = (state_q == ST_SAVE) || (state_q == ST_RESTORE);
  assign we_o      = (state_q == ST_SAVE);
  assign tr_load_o = (state_q == ST_LOAD_TR);
  assign rd_acc_o  = (state_q == ST_RESTORE) && ack_i;
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign idx_o     = idx_q;
endmodule

// File: rtl/tsw_ctx_store.sv
module tsw_ctx_store #(
  parameter int unsigned XLEN  = 16,
  parameter int unsigned NF    = 12,
  parameter int unsigned CNT_W = $clog2(NF)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               snap_i,
  input  logic [NF*XLEN-1:0] ctx_i,
  input  logic [CNT_W-1:0]   idx_i,
  input  logic               wr_i,
  input  logic [XLEN-1:0]    rdata_i,
  output logic [XLEN-1:0]    wdata_o,
  output logic [NF*XLEN-1:0] ctx_o
);
  logic [XLEN-1:0] snap_q [NF];
  logic [XLEN-1:0] bank_q [NF];

  // snapshot keeps save data independent of ctx_i after the command
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NF; i++) snap_q[i] <= '0;
    end else if (snap_i) begin
      for (int i = 0; i < NF; i++) snap_q[i] <= ctx_i[i*XLEN +: XLEN];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NF; i++) bank_q[i] <= '0;
    end else if (wr_i) begin
      bank_q[idx_i] <= rdata_i;
    end
  end

  assign wdata_o = snap_q[idx_i];

  for (genvar g = 0; g < NF; g++) begin : g_ctx_out
    assign ctx_o[g*XLEN +: XLEN] = bank_q[g];
  end
endmodule

// File: rtl/task_switch_seq.sv
module task_switch_seq #(
  parameter int unsigned XLEN    = 16,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned SEL_W   = 3,
  parameter int unsigned NUM_GPR = 4,
  parameter int unsigned NUM_SEG = 2,
  parameter int unsigned NUM_STK = 2,
  localparam int unsigned NF     = tsw_pkg::ctx_words(NUM_GPR, NUM_SEG, NUM_STK),
  localparam int unsigned CTX_W  = NF * XLEN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dt_we_i,
  input  logic [SEL_W-1:0]  dt_idx_i,
  input  logic [ADDR_W-1:0] dt_base_i,
  input  logic              jmp_i,
  input  logic [SEL_W-1:0]  jmp_sel_i,
  input  logic [CTX_W-1:0]  ctx_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [XLEN-1:0]   ip_o,
  output logic [CTX_W-1:0]  ctx_o,
  output logic [SEL_W-1:0]  tr_sel_o,
  output logic [ADDR_W-1:0] tr_base_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [XLEN-1:0]   mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [XLEN-1:0]   mem_rdata_i
);
  localparam int unsigned CntW  = $clog2(NF);
  localparam int unsigned IpOfs = tsw_pkg::ip_offset(NUM_GPR);

  logic              start, tr_load, rd_acc;
  logic [CntW-1:0]   idx;
  logic [SEL_W-1:0]  pend_sel_q, tr_sel_q;
  logic [ADDR_W-1:0] tr_base_q, new_base;

  tsw_fsm #(.NF(NF), .CNT_W(CntW)) u_fsm (
    .clk_i, .rst_ni,
    .jmp_i,
    .ack_i    (mem_ack_i),
    .start_o  (start),
    .req_o    (mem_req_o),
    .we_o     (mem_we_o),
    .tr_load_o(tr_load),
    .rd_acc_o (rd_acc),
    .busy_o,
    .done_o,
    .idx_o    (idx)
  );

  tsw_desc_table #(.SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_dt (
    .clk_i, .rst_ni,
    .we_i     (dt_we_i),
    .wr_idx_i (dt_idx_i),
    .wr_base_i(dt_base_i),
    .rd_idx_i (pend_sel_q),
    .rd_base_o(new_base)
  );

  tsw_ctx_store #(.XLEN(XLEN), .NF(NF), .CNT_W(CntW)) u_ctx (
    .clk_i, .rst_ni,
    .snap_i (start),
    .ctx_i,
    .idx_i  (idx),
    .wr_i   (rd_acc),
    .rdata_i(mem_rdata_i),
    .wdata_o(mem_wdata_o),
    .ctx_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_sel_q <= '0;
    else if (start) pend_sel_q <= jmp_sel_i;
  end

  // task register: selector plus cached descriptor base
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tr_sel_q  <= '0;
      tr_base_q <= '0;
    end else if (tr_load) begin
      tr_sel_q  <= pend_sel_q;
      tr_base_q <= new_base;
    end
  end

  assign mem_addr_o = tr_base_q + ADDR_W'(idx);
  assign tr_sel_o   = tr_sel_q;
  assign tr_base_o  = tr_base_q;
  assign ip_o       = ctx_o[IpOfs*XLEN +: XLEN];
endmodule

// File: rtl/tsw_checker.sv
module tsw_checker #(
  parameter int unsigned XLEN   = 16,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned SEL_W  = 3,
  parameter int unsigned NF     = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              jmp_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [XLEN-1:0]   mem_wdata_o,
  input logic              mem_ack_i,
  input logic [SEL_W-1:0]  tr_sel_o,
  input logic [ADDR_W-1:0] tr_base_o
);
  logic [ADDR_W-1:0] rel_ofs;
  assign rel_ofs = mem_addr_o - tr_base_o;

  p_busy_after_jmp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jmp_i && !busy_o) |=> busy_o);

  p_tr_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ack_i) |=> ($stable(tr_sel_o) && $stable(tr_base_o)));

  p_no_write_after_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |=> !(mem_req_o && mem_we_o));

  p_lower_only_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (rel_ofs < ADDR_W'(NF)));

  p_req_in_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && !mem_req_o));

  p_req_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));
endmodule

bind task_switch_seq tsw_checker #(
  .XLEN(XLEN), .ADDR_W(ADDR_W), .SEL_W(SEL_W), .NF(NF)
) u_tsw_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .jmp_i      (jmp_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .mem_wdata_o(mem_wdata_o),
  .mem_ack_i  (mem_ack_i),
  .tr_sel_o   (tr_sel_o),
  .tr_base_o  (tr_base_o)
);

// File: tb/task_switch_seq_bench.sv
`timescale 1ns/1ps
module task_switch_seq_bench;
  localparam int XLEN = 16, ADDR_W = 12, SEL_W = 3, NF = 12, SEG = 32, MEMW = 256;
  localparam int LOGN = 512;

  // vector: [15] extra jump while busy, [14:12] target, [11:8] wait states, [7:0] seed
  localparam logic [15:0] VEC [6] = '{
    16'h3_0_11, 16'hD_2_22, 16'h5_1_33, 16'h0_0_44, 16'h7_3_55, 16'hA_0_66
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic              dt_we = 1'b0, jmp = 1'b0;
  logic [SEL_W-1:0]  dt_idx = '0, jmp_sel = '0;
  logic [ADDR_W-1:0] dt_base = '0;
  logic [NF*XLEN-1:0] ctx_in = '0;
  logic busy, done, mem_req, mem_we, mem_ack;
  logic [XLEN-1:0] ip, mem_wdata, mem_rdata;
  logic [NF*XLEN-1:0] ctx_out;
  logic [SEL_W-1:0] tr_sel;
  logic [ADDR_W-1:0] tr_base, mem_addr;

  task_switch_seq u_task_switch_seq (
    .clk_i(clk), .rst_ni(rst_ni), .dt_we_i(dt_we), .dt_idx_i(dt_idx), .dt_base_i(dt_base),
    .jmp_i(jmp), .jmp_sel_i(jmp_sel), .ctx_i(ctx_in), .busy_o(busy), .done_o(done),
    .ip_o(ip), .ctx_o(ctx_out), .tr_sel_o(tr_sel), .tr_base_o(tr_base),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [XLEN-1:0] fill(int a);
    return 16'hC000 ^ XLEN'(a * 37);
  endfunction

  // memory model with access log
  logic [XLEN-1:0] mem [MEMW];
  logic [ADDR_W-1:0] log_addr [LOGN];
  logic [XLEN-1:0] log_data [LOGN];
  logic log_we [LOGN];
  logic [SEL_W-1:0] log_sel [LOGN];
  int nacc = 0;
  int ack_ws = 0;
  int wcnt = 0;

  always @(posedge clk) begin
    if (!rst_ni) begin
      for (int a = 0; a < MEMW; a++) mem[a] <= fill(a);
    end else if (mem_req && mem_ack) begin
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      if (nacc < LOGN) begin
        log_addr[nacc] <= mem_addr;
        log_data[nacc] <= mem_we ? mem_wdata : mem[mem_addr[7:0]];
        log_we[nacc]   <= mem_we;
        log_sel[nacc]  <= tr_sel;
      end
      nacc <= nacc + 1;
    end
  end

  always @(negedge clk) begin
    if (!rst_ni || !mem_req) begin
      mem_ack <= 1'b0;
      wcnt    <= 0;
    end else if (wcnt >= ack_ws) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem[mem_addr[7:0]];
      wcnt      <= 0;
    end else begin
      mem_ack <= 1'b0;
      wcnt    <= wcnt + 1;
    end
  end

  int n_chk = 0, n_pass = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (ok) n_pass++;
    else $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_pass, n_chk + 1);
    $finish;
  end

  logic [XLEN-1:0] exp_mem [MEMW];
  logic [XLEN-1:0] wv [NF];

  initial begin
    int cur_sel, start_idx, cyc;
    bit seen;
    for (int a = 0; a < MEMW; a++) exp_mem[a] = fill(a);
    mem_ack = 1'b0;
    mem_rdata = '0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(busy == 0 && done == 0 && mem_req == 0, "R1 idle outputs", {busy, done, mem_req}, 0);
    chk(tr_sel == 0 && tr_base == 0, "R1 task register", {tr_sel, tr_base}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(busy == 0 && mem_req == 0, "R1 idle after release", {busy, mem_req}, 0);
    for (int s = 0; s < 8; s++) begin
      dt_we = 1'b1; dt_idx = SEL_W'(s); dt_base = ADDR_W'(s * SEG);
      @(negedge clk);
    end
    dt_we = 1'b0;
    cur_sel = 0;

    foreach (VEC[v]) begin
      int t, ws, ob, nb;
      logic [7:0] seed;
      bit extra;
      extra = VEC[v][15];
      t = int'(VEC[v][14:12]);
      ws = int'(VEC[v][11:8]);
      seed = VEC[v][7:0];
      ob = cur_sel * SEG;
      nb = t * SEG;
      ack_ws = ws;
      for (int k = 0; k < NF; k++) begin
        wv[k] = 16'h5000 ^ {seed, 8'(k)};
        ctx_in[k*XLEN +: XLEN] = wv[k];
      end
      start_idx = nacc;
      jmp = 1'b1; jmp_sel = SEL_W'(t);
      @(negedge clk);
      jmp = 1'b0;
      ctx_in = ~ctx_in;  // must not affect saved words (R3)
      chk(busy == 1, "R2 busy after jump", busy, 1);
      if (extra) begin
        @(negedge clk);
        jmp = 1'b1; jmp_sel = ~SEL_W'(t);  // R8
        @(negedge clk);
        jmp = 1'b0;
      end
      seen = 0;
      cyc = 0;
      while (!seen && cyc < 2000) begin
        @(negedge clk);
        cyc++;
        if (done) seen = 1;
      end
      chk(seen, "R7 done pulse seen", 32'(seen), 1);
      for (int k = 0; k < NF; k++) exp_mem[ob + k] = wv[k];
      chk(busy == 0, "R7 busy low at done", busy, 0);
      chk(ip == exp_mem[nb + 5], "R7 ip from new segment", ip, exp_mem[nb + 5]);
      for (int k = 0; k < NF; k++)
        chk(ctx_out[k*XLEN +: XLEN] == exp_mem[nb + k],
            (t == cur_sel) ? "R9 same-task restore" : "R5 restored word",
            ctx_out[k*XLEN +: XLEN], exp_mem[nb + k]);
      chk(tr_sel == SEL_W'(t), extra ? "R8 target kept" : "R4 new selector", tr_sel, t);
      chk(tr_base == ADDR_W'(nb), "R4 cached base", tr_base, nb);
      chk(nacc - start_idx == 2 * NF, "R4 access count", nacc - start_idx, 2 * NF);
      for (int k = 0; k < NF; k++) begin
        int w, r;
        w = start_idx + k;
        r = start_idx + NF + k;
        chk(log_we[w] == 1 && log_addr[w] == ADDR_W'(ob + k) && log_data[w] == wv[k],
            "R3 save word", {log_addr[w], log_data[w]}, {ADDR_W'(ob + k), wv[k]});
        chk(log_sel[w] == SEL_W'(cur_sel), "R4 old task during save", log_sel[w], cur_sel);
        chk(log_we[r] == 0 && log_addr[r] == ADDR_W'(nb + k) && log_sel[r] == SEL_W'(t),
            "R5 restore read", {log_we[r], log_addr[r]}, {1'b0, ADDR_W'(nb + k)});
      end
      for (int k = NF; k < SEG; k++) begin
        chk(mem[ob + k] == fill(ob + k), "R6 old upper area", mem[ob + k], fill(ob + k));
        chk(mem[nb + k] == fill(nb + k), "R6 new upper area", mem[nb + k], fill(nb + k));
      end
      @(negedge clk);
      chk(done == 0, "R7 done lasts one cycle", done, 0);
      cur_sel = t;
    end

    // directed: command during reset is ignored, reset restores R1 state
    jmp = 1'b1; jmp_sel = 3'd4; rst_ni = 1'b0;
    @(negedge clk);
    jmp = 1'b0;
    @(negedge clk);
    chk(busy == 0 && tr_sel == 0 && tr_base == 0, "R1 mid-run reset",
        {busy, tr_sel, tr_base}, 0);

    $display("%0d/%0d checks passed", n_pass, n_chk);
    $finish;
  end
endmodule